// File: doc/BRIEF.md
# Aperture Page Relocation Unit

The unit remaps a fixed, contiguous window of bus addresses onto scattered 4 KB physical pages. It keeps one table entry per page of the window. Each entry carries a valid flag and a physical page frame. A client presents a request address and gets back a translated physical address, or a fault indication, one cycle after the request is accepted. Only the page part of the address is replaced. The byte offset inside the page passes through unchanged.

Software never addresses the table directly. It uses three 32-bit registers reached through a plain read/write port: a control register holding the global translate enable, a pointer register that holds a byte address inside the window, and a data register. A write to the data register updates the entry that the pointer selects, and a read of the data register returns that entry. Reading the control register back returns its current value, so software can use that read to confirm that earlier writes have landed.

The client side is a valid/ready stream. A request is taken in any cycle where `req_valid` and `req_ready` are both high. While a response is pending and `rsp_ready` is low, the response stays frozen and `req_ready` is low, so back-pressure from the response side stalls the request side with no loss. `req_ready` depends only on response state, never on `req_valid`.

Top module: `aart_top`

## Requirements
- R1: After reset the control register reads 0, every table entry reads 0, `rsp_valid` is 0, and a lookup faults.
- R2: The control register sits at byte offset 0x0 (`reg_addr[3:2]`=0). Writing it stores bit 0 as the translate enable, and a read returns `{31'b0, enable}`. Read data appears on `reg_rdata` one cycle after a read strobe.
- R3: The pointer register sits at offset 0x4 (`reg_addr[3:2]`=1) and reads back the full 32-bit value last written.
- R4: A write to the data register (offset 0x8, `reg_addr[3:2]`=2) stores bit 31 as the valid flag and bits 30:12 as the page frame into entry (pointer - base) >> 12. Reading the data register returns that entry with bits 11:0 reading 0.
- R5: When the pointer lies below the window base or at or above base + entries*4096, a data-register write changes no entry, and a data-register read returns 0.
- R6: An accepted request that is enabled, inside the window and maps to a valid entry responds with fault 0 and address `{1'b0, frame, req_addr[11:0]}`. Any faulting response carries address 0.
- R7: With the enable at 0, every accepted request faults, whatever the table holds.
- R8: A request address below the base, or at or above the window end, faults. The last byte of the window still translates.
- R9: A request whose entry has valid flag 0 faults. Writing 0 to a mapped entry unmaps it.
- R10: The response appears in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `req_ready` is low.
- R11: Offset 0xC (`reg_addr[3:2]`=3) reads 0, and writes to it have no effect on any register or entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (ignored when reg_we is high) |
| reg_addr | input | 4 | Register byte offset; bits 3:2 select the word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_re |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 32 | Client request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Request could not be translated |

## Verification
Lookups use random addresses spread over the window and just past both edges. The table has a random mix of mapped and unmapped entries with random frames, so correct frame substitution is separated from offset pass-through and from the valid-flag gating. The enable is toggled in the middle of a run, which separates a fault caused by disable from one caused by a missing mapping. Directed cases hit the first and last byte of the window, one byte below it, the first byte past it, pointer values outside the window, and a stalled response with a second request waiting, which shows that back-pressure neither drops nor reorders a request.

// File: rtl/aart_pkg.sv
package aart_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = 31 - PAGE_SHIFT;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_RSVD = 2'd3
  } win_sel_e;

  typedef struct packed {
    logic               vld;
    logic [FRAME_W-1:0] frame;
  } pte_t;

  function automatic pte_t word_to_pte(input logic [31:0] w);
    pte_t p;
    p.vld   = w[31];
    p.frame = w[30:PAGE_SHIFT];
    return p;
  endfunction

  function automatic logic [31:0] pte_to_word(input pte_t p);
    return {p.vld, p.frame, {PAGE_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/aart_decode.sv
module aart_decode #(
  parameter logic [31:0] BASE      = 32'h4000_0000,
  parameter int          N_ENTRIES = 1024,
  localparam int         IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic [31:0]      addr,
  output logic             in_win,
  output logic [IDX_W-1:0] idx
);
  import aart_pkg::*;

  localparam logic [32:0] SPAN = 33'(N_ENTRIES) << PAGE_SHIFT;

  logic [32:0] off;
  logic        unused_low;

  assign off        = {1'b0, addr} - {1'b0, BASE};
  assign in_win     = !off[32] && (off < SPAN);
  assign idx        = off[PAGE_SHIFT +: IDX_W];
  assign unused_low = ^off[PAGE_SHIFT-1:0];

endmodule

// File: rtl/aart_table.sv
module aart_table #(
  parameter int  N_ENTRIES = 1024,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  aart_pkg::pte_t    wr_pte,
  input  logic [IDX_W-1:0]  rd_sw_idx,
  output aart_pkg::pte_t    rd_sw_pte,
  input  logic [IDX_W-1:0]  rd_cl_idx,
  output aart_pkg::pte_t    rd_cl_pte
);
  import aart_pkg::*;

  pte_t mem [N_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_pte;
    end
  end

  assign rd_sw_pte = mem[rd_sw_idx];
  assign rd_cl_pte = mem[rd_cl_idx];

endmodule

// File: rtl/aart_regs.sv
module aart_regs #(
  parameter int  N_ENTRIES = 1024,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic               reg_re,
  input  aart_pkg::win_sel_e reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [31:0]        ptr_q,
  input  logic               ptr_in_win,
  input  logic [IDX_W-1:0]   ptr_idx,
  output logic               cfg_en,
  output logic               tbl_we,
  output logic [IDX_W-1:0]   tbl_widx,
  output aart_pkg::pte_t     tbl_wpte,
  input  aart_pkg::pte_t     tbl_rpte
);
  import aart_pkg::*;

  logic [31:0] rd_mux;

  assign tbl_we   = reg_we && (reg_sel == SEL_DATA) && ptr_in_win;
  assign tbl_widx = ptr_idx;
  assign tbl_wpte = word_to_pte(reg_wdata);

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: rd_mux = {31'b0, cfg_en};
      SEL_PTR:  rd_mux = ptr_q;
      SEL_DATA: rd_mux = ptr_in_win ? pte_to_word(tbl_rpte) : 32'b0;
      default:  rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      ptr_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        if (reg_sel == SEL_CTRL) cfg_en <= reg_wdata[0];
        if (reg_sel == SEL_PTR)  ptr_q  <= reg_wdata;
      end else if (reg_re) begin
        reg_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/aart_lookup.sv
module aart_lookup #(
  parameter int  N_ENTRIES = 1024,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_in_win,
  input  aart_pkg::pte_t    req_pte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_addr,
  output logic              rsp_fault
);
  import aart_pkg::*;

  logic        take;
  logic        miss;
  logic [31:0] phys;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign miss      = !cfg_en || !req_in_win || !req_pte.vld;
  assign phys      = {1'b0, req_pte.frame, req_addr[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_fault <= miss;
      rsp_addr  <= miss ? 32'b0 : phys;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/aart_top.sv
module aart_top #(
  parameter logic [31:0] BASE      = 32'h4000_0000,
  parameter int          N_ENTRIES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault
);
  import aart_pkg::*;

  localparam int IDX_W = $clog2(N_ENTRIES);

  win_sel_e         sel;
  logic [31:0]      ptr_q;
  logic             ptr_in_win;
  logic [IDX_W-1:0] ptr_idx;
  logic             req_in_win;
  logic [IDX_W-1:0] req_idx;
  logic             cfg_en;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_widx;
  pte_t             tbl_wpte;
  pte_t             sw_pte;
  pte_t             cl_pte;
  logic             unused_addr;

  assign sel         = win_sel_e'(reg_addr[3:2]);
  assign unused_addr = ^reg_addr[1:0];

  aart_decode #(.BASE(BASE), .N_ENTRIES(N_ENTRIES)) u_dec_ptr (
    .addr(ptr_q), .in_win(ptr_in_win), .idx(ptr_idx)
  );

  aart_decode #(.BASE(BASE), .N_ENTRIES(N_ENTRIES)) u_dec_req (
    .addr(req_addr), .in_win(req_in_win), .idx(req_idx)
  );

  aart_table #(.N_ENTRIES(N_ENTRIES)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_pte(tbl_wpte),
    .rd_sw_idx(ptr_idx), .rd_sw_pte(sw_pte),
    .rd_cl_idx(req_idx), .rd_cl_pte(cl_pte)
  );

  aart_regs #(.N_ENTRIES(N_ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_sel(sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ptr_q(ptr_q), .ptr_in_win(ptr_in_win), .ptr_idx(ptr_idx),
    .cfg_en(cfg_en),
    .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wpte(tbl_wpte),
    .tbl_rpte(sw_pte)
  );

  aart_lookup #(.N_ENTRIES(N_ENTRIES)) u_lkp (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_in_win(req_in_win), .req_pte(cl_pte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

endmodule

// File: rtl/aart_chk.sv
module aart_chk #(
  parameter logic [31:0] BASE = 32'h4000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        reg_we,
  input logic        reg_re,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault
);

  // R10: a stalled response stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));

  // R10: no new request while stalled
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R10: an accepted request answers next cycle
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R6: a fault carries a zero address
  p_zero_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == 32'b0);

  // R6: byte offset passes through on a hit
  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_fault || (rsp_addr[11:0] == $past(req_addr[11:0]) && !rsp_addr[31]));

  // R7: disabled translation always faults
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !cfg_en |=> rsp_fault);

  // R8: below the base always faults
  p_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_addr < BASE) |=> rsp_fault);

  // R2: control readback has only bit 0
  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && !reg_we && reg_addr[3:2] == 2'd0 |=> reg_rdata[31:1] == 31'b0);

  // R11: reserved word reads zero
  p_rsvd_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && !reg_we && reg_addr[3:2] == 2'd3 |=> reg_rdata == 32'b0);

endmodule

bind aart_top aart_chk #(.BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
  .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
);

// File: tb/sim_aart_top.sv
`timescale 1ns/1ps
module sim_aart_top;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int          N    = 64;
  localparam logic [31:0] WEND = BASE + N * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] model [N];
  logic        model_en = 1'b0;

  always #2.5 clk = ~clk;

  aart_top #(.BASE(BASE), .N_ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_xlate(input logic [31:0] a);
    logic [31:0] e;
    if (!model_en || a < BASE || a >= WEND) return {1'b1, 32'b0};
    e = model[(a - BASE) >> 12];
    if (!e[31]) return {1'b1, 32'b0};
    return {1'b0, 1'b0, e[30:12], a[11:0]};
  endfunction

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {w, 2'b00}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = {w, 2'b00};
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_entry(input int i, input logic [31:0] d);
    wr(2'd1, BASE + i * 4096 + ($urandom & 32'hFFF));
    wr(2'd2, d);
    model[i] = d & 32'hFFFF_F000;
  endtask

  task automatic look(input string rq, input logic [31:0] a);
    logic [32:0] e;
    e = exp_xlate(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({rq, " fault"}, {31'b0, rsp_fault}, {31'b0, e[32]});
    chk({rq, " addr"}, rsp_addr, e[31:0]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [32:0] ea, eb;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
    wr(2'd1, BASE + 5 * 4096); rd(2'd2, d); chk("R1 entry", d, 32'd0);
    look("R1 lookup", BASE + 5 * 4096);

    // R2 control
    wr(2'd0, 32'hFFFF_FFFF); model_en = 1'b1;
    rd(2'd0, d); chk("R2 ctrl on", d, 32'd1);
    wr(2'd0, 32'h0000_0002); model_en = 1'b0;
    rd(2'd0, d); chk("R2 ctrl off", d, 32'd0);
    wr(2'd0, 32'd1); model_en = 1'b1;

    // R3 pointer readback
    wr(2'd1, 32'hDEAD_BEEF); rd(2'd1, d); chk("R3 ptr", d, 32'hDEAD_BEEF);

    // R4 entry store and readback
    set_entry(0, 32'hFFFF_FFFF);
    wr(2'd1, BASE + 32'h0ABC); rd(2'd2, d); chk("R4 entry0", d, 32'hFFFF_F000);
    set_entry(N - 1, 32'h8123_4567);
    rd(2'd2, d); chk("R4 entryN", d, 32'h8123_4000);

    // R6 / R8 window edges
    look("R6 first byte", BASE);
    look("R8 last byte", WEND - 1);
    look("R8 below", BASE - 1);
    look("R8 end", WEND);

    // R5 pointer outside window
    wr(2'd1, BASE - 4); wr(2'd2, 32'h8000_0000);
    rd(2'd2, d); chk("R5 read below", d, 32'd0);
    wr(2'd1, WEND); wr(2'd2, 32'h8000_0000);
    rd(2'd2, d); chk("R5 read end", d, 32'd0);
    wr(2'd1, BASE); rd(2'd2, d); chk("R5 entry0 kept", d, 32'hFFFF_F000);
    wr(2'd1, WEND - 4096); rd(2'd2, d); chk("R5 entryN kept", d, 32'h8123_4000);

    // R11 reserved word
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R11 read", d, 32'd0);
    rd(2'd0, d); chk("R11 ctrl kept", d, 32'd1);
    rd(2'd1, d); chk("R11 ptr kept", d, WEND - 4096);

    // R9 unmap
    set_entry(3, 32'h8055_5000);
    look("R9 mapped", BASE + 3 * 4096 + 12'h321);
    set_entry(3, 32'h0);
    look("R9 unmapped", BASE + 3 * 4096 + 12'h321);

    // R7 disable masks valid entries
    wr(2'd0, 32'd0); model_en = 1'b0;
    look("R7 disabled", BASE);
    wr(2'd0, 32'd1); model_en = 1'b1;

    // R10 back-pressure
    set_entry(7, 32'h8077_7000);
    ea = exp_xlate(BASE + 0 * 4096 + 12'h010);
    eb = exp_xlate(BASE + 7 * 4096 + 12'h020);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = BASE + 12'h010;
    @(negedge clk);
    req_addr = BASE + 7 * 4096 + 12'h020;
    chk("R10 ready low", {31'b0, req_ready}, 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R10 hold valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 hold addr", rsp_addr, ea[31:0]);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second addr", rsp_addr, eb[31:0]);
    chk("R10 second fault", {31'b0, rsp_fault}, {31'b0, eb[32]});
    @(negedge clk);
    chk("R10 drained", {31'b0, rsp_valid}, 32'd0);

    // random mix: R4 R6 R7 R8 R9
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        set_entry($urandom_range(0, N - 1), ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom);
      end else if (op == 3) begin
        model_en = ($urandom_range(0, 3) != 0);
        wr(2'd0, {31'b0, model_en});
      end else if (op == 4) begin
        int i;
        i = $urandom_range(0, N - 1);
        wr(2'd1, BASE + i * 4096 + ($urandom & 32'hFFF));
        rd(2'd2, d); chk("R4 random read", d, model[i]);
      end else begin
        logic [31:0] a;
        a = BASE - 32'h2000 + ($urandom % (N * 4096 + 32'h4000));
        look("R6 R8 R9 random", a);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule